// File: doc/BRIEF.md
# Dual-Channel Sample-Hold Conversion Scheduler

This block decides when a single shared conversion engine runs and for which of two output channels. In single-channel mode the engine serves channel 0 only: every request for channel 0 produces one conversion, and the sample-hold strobes stay low because the output is driven continuously. In dual-channel mode both outputs are held by sample-hold stages. A free-running refresh timer periodically converts channel 0 and then channel 1. On-demand requests for either channel convert only that channel.

The scheduler keeps a minimum spacing between any two conversion strobes. It holds at most one pending request per channel. When both channels are pending it serves channel 0 first. A request that lands while a refresh pair is in progress waits until channel 1 of that pair has been converted. On-demand conversions never move the refresh timer. The spacing is set by a code `s` that gives S = 2^s clock cycles. The refresh period is set by a code `r` that gives P = 2^(r+1) clock cycles.

Top module: `sh_conv_sched`

## Requirements
- R1: In dual mode with refresh enabled, a refresh strobe for channel 0 occurs once every P = 2^(r+1) cycles. Each one is followed by a channel 1 strobe exactly S cycles later when nothing else competes.
- R2: A request sampled at a rising edge outside a refresh produces one strobe for that channel only, visible two rising edges later if the spacing allows.
- R3: A request that becomes pending while a refresh pair is in progress is served S cycles after the channel 1 refresh strobe.
- R4: A channel holds at most one pending request. A further request for that channel, sampled while one is pending, produces no extra strobe.
- R5: Two consecutive convert strobes are always at least S = 2^s cycles apart.
- R6: On-demand strobes do not shift the refresh timer. The channel 0 refresh strobes remain exactly P cycles apart.
- R7: With refresh disabled, no strobe occurs without a request.
- R8: In single mode, every strobe selects channel 0 (conv_ch_o = 0), hold_o stays 0, and requests for channel 1 are ignored.
- R9: When both channels become pending together, channel 0 is converted first and channel 1 follows S cycles later.
- R10: In dual mode, each strobe raises exactly the hold bit of the selected channel (bit 0 for channel 0, bit 1 for channel 1), and no hold bit rises without a strobe.
- R11: After reset, conv_o, conv_ch_o and hold_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Per-channel conversion request pulses, bit n for channel n |
| dual_mode_i | input | 1 | 1 selects dual-channel sample-hold mode, 0 selects single channel 0 |
| refresh_en_i | input | 1 | Enables the automatic refresh of both channels |
| sep_code_i | input | SEP_CODE_W | Spacing code s, spacing S = 2^s cycles |
| ref_code_i | input | REF_CODE_W | Refresh code r, period P = 2^(r+1) cycles |
| conv_o | output | 1 | Convert strobe, one cycle per conversion |
| conv_ch_o | output | 1 | Channel converted by the current strobe |
| hold_o | output | 2 | Per-channel sample-hold strobe |

## Verification
The hardest case to reach is a request that arrives inside the short window of a refresh pair. It must stay deferred past the channel 1 refresh and then be served one spacing later, while the next refresh still lands on its original period. The bench logs every strobe with its cycle number and reads the time of the first refresh from that log. It then places one channel 1 request in the middle of the interval and one channel 0 request on the cycle just before the next refresh. It then checks the full sequence of eight strobe times and channels against values computed from S and P.

// File: rtl/sh_sched_pkg.sv
package sh_sched_pkg;

    typedef enum logic {
        CH0 = 1'b0,
        CH1 = 1'b1
    } chan_e;

    typedef struct packed {
        logic  vld;
        chan_e ch;
    } grant_t;

endpackage

// File: rtl/sh_refresh_timer.sv
module sh_refresh_timer #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = (1 << CODE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = (CNT_W'(1) << ({1'b0, code_i} + 1'b1)) - CNT_W'(1);
        tick_o = run_i && (cnt_q >= limit);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sh_sep_gate.sv
module sh_sep_gate #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              ready_o
);

    logic [CNT_W-1:0] gap_d, gap_q;

    always_comb begin
        ready_o = (gap_q == '0);
        if (fire_i) begin
            gap_d = (CNT_W'(1) << code_i) - CNT_W'(1);
        end else if (!ready_o) begin
            gap_d = gap_q - CNT_W'(1);
        end else begin
            gap_d = gap_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

endmodule

// File: rtl/sh_req_pend.sv
module sh_req_pend
    import sh_sched_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_i,
    input  logic           dual_i,
    input  grant_t         take_i,
    output logic [NCH-1:0] pend_o
);

    logic [NCH-1:0] pend_d, pend_q;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            if (take_i.vld && (int'(take_i.ch) == c)) begin
                pend_d[c] = 1'b0;
            end else if (c > 0 && !dual_i) begin
                pend_d[c] = 1'b0;
            end else begin
                pend_d[c] = pend_q[c] | req_i[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/sh_conv_sched.sv
module sh_conv_sched
    import sh_sched_pkg::*;
#(
    parameter int SEP_CODE_W = 3,
    parameter int REF_CODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            req_i,
    input  logic                  dual_mode_i,
    input  logic                  refresh_en_i,
    input  logic [SEP_CODE_W-1:0] sep_code_i,
    input  logic [REF_CODE_W-1:0] ref_code_i,
    output logic                  conv_o,
    output logic                  conv_ch_o,
    output logic [1:0]            hold_o
);

    localparam int NCH = 2;

    typedef struct packed {
        logic           rf_act;
        logic           rf_ch;
        logic           conv;
        logic           ch;
        logic [NCH-1:0] hold;
    } state_t;

    state_t         st_d, st_q;
    grant_t         grant;
    logic           tick;
    logic           ready;
    logic           run;
    logic           act;
    logic           rch;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] pend_eff;

    assign run = dual_mode_i & refresh_en_i;

    sh_refresh_timer #(
        .CODE_W (REF_CODE_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .code_i (ref_code_i),
        .tick_o (tick)
    );

    sh_sep_gate #(
        .CODE_W (SEP_CODE_W)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (st_d.conv),
        .code_i  (sep_code_i),
        .ready_o (ready)
    );

    sh_req_pend #(
        .NCH (NCH)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .dual_i (dual_mode_i),
        .take_i (grant),
        .pend_o (pend)
    );

    always_comb begin
        st_d      = st_q;
        st_d.conv = 1'b0;
        st_d.ch   = 1'b0;
        st_d.hold = '0;
        grant     = '{vld: 1'b0, ch: CH0};
        pend_eff  = {pend[1] & dual_mode_i, pend[0]};
        act       = run & (st_q.rf_act | tick);
        rch       = st_q.rf_act ? st_q.rf_ch : 1'b0;

        if (act) begin
            if (ready) begin
                st_d.conv   = 1'b1;
                st_d.ch     = rch;
                st_d.rf_act = ~rch;
                st_d.rf_ch  = 1'b1;
            end else begin
                st_d.rf_act = 1'b1;
                st_d.rf_ch  = rch;
            end
        end else begin
            st_d.rf_act = 1'b0;
            st_d.rf_ch  = 1'b0;
            if (ready && (pend_eff != '0)) begin
                grant.vld = 1'b1;
                grant.ch  = pend_eff[0] ? CH0 : CH1;
                st_d.conv = 1'b1;
                st_d.ch   = logic'(grant.ch);
            end
        end

        if (st_d.conv && dual_mode_i) begin
            st_d.hold[st_d.ch] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_o    = st_q.conv;
    assign conv_ch_o = st_q.ch;
    assign hold_o    = st_q.hold;

endmodule

// File: rtl/sh_conv_sched_chk.sv
module sh_conv_sched_chk #(
    parameter int SEP_CODE_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  dual_mode_i,
    input logic [SEP_CODE_W-1:0] sep_code_i,
    input logic                  conv_o,
    input logic                  conv_ch_o,
    input logic [1:0]            hold_o
);

    localparam int SW = (1 << SEP_CODE_W) + 2;

    logic [SW-1:0] since_q;
    logic          seen_q;
    logic [SW-1:0] need;

    assign need = SW'(1) << sep_code_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (conv_o) begin
            since_q <= SW'(1);
            seen_q  <= 1'b1;
        end else if (since_q != '1) begin
            since_q <= since_q + SW'(1);
        end
    end

    p_min_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_o && seen_q) |-> (since_q >= need));

    p_hold_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hold_o));

    p_hold_needs_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o != 2'b00) |-> conv_o);

    p_hold_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_o && $past(dual_mode_i)) |-> hold_o[conv_ch_o]);

    p_single_ch0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_o && !$past(dual_mode_i)) |-> (!conv_ch_o && hold_o == 2'b00));

endmodule

bind sh_conv_sched sh_conv_sched_chk #(
    .SEP_CODE_W (SEP_CODE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dual_mode_i (dual_mode_i),
    .sep_code_i  (sep_code_i),
    .conv_o      (conv_o),
    .conv_ch_o   (conv_ch_o),
    .hold_o      (hold_o)
);

// File: tb/sh_conv_sched_tb.sv
module sh_conv_sched_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = 2'b00;
    logic       dual = 1'b0;
    logic       ref_en = 1'b0;
    logic [2:0] sep_code = 3'd2;
    logic [2:0] ref_code = 3'd4;
    logic       conv;
    logic       conv_ch;
    logic [1:0] hold;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int n_log = 0;
    int lt [256];
    int lc [256];
    int lh [256];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sh_conv_sched u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .dual_mode_i  (dual),
        .refresh_en_i (ref_en),
        .sep_code_i   (sep_code),
        .ref_code_i   (ref_code),
        .conv_o       (conv),
        .conv_ch_o    (conv_ch),
        .hold_o       (hold)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && conv && n_log < 256) begin
            lt[n_log] = cyc;
            lc[n_log] = int'(conv_ch);
            lh[n_log] = int'(hold);
            n_log = n_log + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic pulse(input logic [1:0] r);
        req = r;
        @(negedge clk);
        req = 2'b00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R11
    task automatic t_reset;
        chk(conv == 1'b0, "R11 conv", int'(conv), 0);
        chk(conv_ch == 1'b0, "R11 conv_ch", int'(conv_ch), 0);
        chk(hold == 2'b00, "R11 hold", int'(hold), 0);
    endtask

    // R8, R2, R5 in single mode with S = 4
    task automatic t_single;
        int base;
        int k;
        dual = 1'b0; sep_code = 3'd2;
        idle(2);
        base = n_log; k = cyc;
        pulse(2'b01);
        wait_cyc(k + 2);
        pulse(2'b01);
        idle(20);
        chk(n_log - base == 2, "R5 single strobe count", n_log - base, 2);
        chk(lt[base] == k + 2, "R2 single latency", lt[base] - k, 2);
        chk(lc[base] == 0 && lh[base] == 0, "R8 ch0 no hold", lc[base] * 4 + lh[base], 0);
        chk(lt[base+1] - lt[base] == 4, "R5 spacing", lt[base+1] - lt[base], 4);
        base = n_log;
        pulse(2'b10);
        idle(40);
        chk(n_log == base, "R8 ch1 request ignored", n_log - base, 0);
    endtask

    // R4 with S = 32, refresh off
    task automatic t_drop;
        int base;
        int k;
        dual = 1'b1; ref_en = 1'b0; sep_code = 3'd5;
        idle(2);
        base = n_log; k = cyc;
        pulse(2'b01);
        wait_cyc(k + 4);
        pulse(2'b10);
        wait_cyc(k + 10);
        pulse(2'b10);
        idle(140);
        chk(n_log - base == 2, "R4 extra request dropped", n_log - base, 2);
        chk(lt[base+1] == k + 34 && lc[base+1] == 1, "R4 ch1 after spacing", lt[base+1] - k, 34);
    endtask

    // R9 and R7 with S = 4
    task automatic t_both;
        int base;
        int k;
        dual = 1'b1; ref_en = 1'b0; sep_code = 3'd2;
        idle(2);
        base = n_log; k = cyc;
        pulse(2'b11);
        idle(20);
        chk(n_log - base == 2, "R9 two strobes", n_log - base, 2);
        chk(lt[base] == k + 2 && lc[base] == 0, "R9 ch0 first", lc[base], 0);
        chk(lt[base+1] == k + 6 && lc[base+1] == 1, "R9 ch1 after S", lt[base+1] - k, 6);
        chk(lh[base] == 1 && lh[base+1] == 2, "R10 hold per channel", lh[base] * 4 + lh[base+1], 6);
        base = n_log;
        idle(100);
        chk(n_log == base, "R7 no strobes without refresh", n_log - base, 0);
    endtask

    // R1, R2, R3, R6, R10 with S = 4, P = 32
    task automatic t_refresh;
        int base;
        int r;
        int exp_t [8];
        int exp_c [8];
        dual = 1'b1; sep_code = 3'd2; ref_code = 3'd4;
        idle(2);
        base = n_log;
        ref_en = 1'b1;
        while (n_log == base) @(negedge clk);
        r = lt[base];
        wait_cyc(r + 10);
        pulse(2'b10);
        wait_cyc(r + 31);
        pulse(2'b01);
        wait_cyc(r + 90);
        ref_en = 1'b0;
        idle(150);
        exp_t = '{r, r + 4, r + 12, r + 32, r + 36, r + 40, r + 64, r + 68};
        exp_c = '{0, 1, 1, 0, 1, 0, 0, 1};
        chk(n_log - base >= 8, "R1 strobe count", n_log - base, 8);
        chk(lc[base] == 0, "R1 refresh starts with ch0", lc[base], 0);
        for (int i = 1; i < 8; i++) begin
            chk(lt[base+i] == exp_t[i], "R1 R2 R3 R6 strobe time", lt[base+i] - r, exp_t[i] - r);
            chk(lc[base+i] == exp_c[i], "R1 R2 R3 strobe channel", lc[base+i], exp_c[i]);
        end
        for (int i = 0; i < 8; i++) begin
            chk(lh[base+i] == (1 << exp_c[i]), "R10 hold matches", lh[base+i], 1 << exp_c[i]);
        end
        chk(lt[base+6] - lt[base+3] == 32, "R6 refresh period kept", lt[base+6] - lt[base+3], 32);
    endtask

    always @(negedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_drop();
        t_both();
        t_refresh();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule